// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block runs next to a simple program counter and removes the cost of counted loops. A setup command gives an iteration count, the address of the last instruction of the loop body, and the address of the setup instruction itself. The block stores these on a small hardware stack. The loop start is the address after the setup instruction. In every cycle the block compares the current fetch address with the end address of the innermost active loop. On a match it either redirects the next fetch to the loop start and decrements the count, or lets the fetch fall through and retires the loop. All of this happens in the cycle that fetches the last body instruction, so a loop costs no cycles beyond its body.

Loops nest up to a parameterised depth. Only the innermost entry is compared with the fetch address. When an inner loop ends on the same address as its enclosing loop, the inner loop is retired and the enclosing loop is tested in the same cycle. An abort input discards the innermost loop. Pushing onto a full stack and popping an empty one each set a sticky flag.

A three-state occupancy machine tracks the stack and drives `loop_active`. Its states are ST_EMPTY, ST_NESTED (at least one entry, room for more) and ST_FULL. Its transitions are named:
- *push* moves ST_EMPTY to ST_NESTED, or to ST_FULL when the depth is 1.
- *fill* moves ST_NESTED to ST_FULL.
- *drain* moves ST_NESTED or ST_FULL back to ST_EMPTY when the last entry retires or is aborted.
- *release* moves ST_FULL to ST_NESTED.

Top module: `hwloop_ctrl`

## Requirements
- R1: A setup with `setup_valid` high pushes an entry. The entry holds start = `setup_pc`+1, the end address and the count. `loop_active` is high from the next cycle on.
- R2: When `pc_in` equals the innermost end address and the stored count is above 1, `redirect_valid` is high in that same cycle and `redirect_addr` equals the loop start. The count then decrements by one.
- R3: A loop set up with count N fetches its body exactly N times. On the last pass there is no redirect and the entry is popped, which makes the enclosing loop innermost again.
- R4: A setup count of 0 behaves as a count of 1, so the body runs once with no redirect.
- R5: When no redirect is taken, `redirect_valid` is low and `redirect_addr` is zero. With no loop active, no redirect is ever taken.
- R6: Loops nest up to DEPTH levels. Inner loops with end addresses different from their parents' complete all their iterations inside every pass of the outer loop.
- R7: A setup that finds the stack full, after any pop made in the same cycle, is ignored and sets `overflow`. `overflow` stays high until reset.
- R8: `abort` pops the innermost entry and blocks the end-address test in that cycle. An abort with an empty stack sets `underflow`, which stays high until reset.
- R9: If an inner loop on its last pass ends on the same address as the enclosing loop, the inner loop is popped and the enclosing loop is tested in the same cycle. That cycle redirects to the outer start when the outer count is above 1.
- R10: Reset empties the stack and clears `loop_active`, `redirect_valid`, `overflow` and `underflow`. The stack never holds more than DEPTH entries.

When a setup and an end-address match fall in the same cycle, the match is handled first and the new entry is pushed on top of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_in | input | ADDR_W | Address fetched this cycle |
| setup_valid | input | 1 | Loop setup command this cycle |
| setup_count | input | CNT_W | Iteration count (0 treated as 1) |
| setup_end_addr | input | ADDR_W | Address of the last body instruction |
| setup_pc | input | ADDR_W | Address of the setup instruction |
| abort | input | 1 | Discard the innermost loop |
| redirect_valid | output | 1 | Next fetch goes to `redirect_addr` |
| redirect_addr | output | ADDR_W | Loop start when redirecting, else zero |
| loop_active | output | 1 | At least one loop is stacked |
| overflow | output | 1 | Sticky: a setup was dropped on a full stack |
| underflow | output | 1 | Sticky: an abort hit an empty stack |

## Verification
The retirement of an inner loop and the branch-back of its enclosing loop can land in one cycle when both loops share an end address. The bench provokes this by sweeping outer and inner counts over a program whose two loops end on the same instruction. The bench follows the redirects as a fetch unit would. Each run is judged by its total fetch count, which must be 1 + A·(2 + 3B), and by its redirect count, (A−1) + A·(B−1), both computed from the counts alone.

// File: rtl/hwloop_pkg.sv
`timescale 1ns/1ps
package hwloop_pkg;

    // Occupancy of the loop stack.
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } occ_state_e;

    // Which stack entry has its count decremented this cycle.
    typedef enum logic [1:0] {
        DEC_NONE = 2'd0,
        DEC_TOP  = 2'd1,
        DEC_NEXT = 2'd2
    } dec_sel_e;

endpackage

// File: rtl/hwloop_stack.sv
`timescale 1ns/1ps
module hwloop_stack
    import hwloop_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pop_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_start,
    input  logic [ADDR_W-1:0] push_end,
    input  logic [CNT_W-1:0]  push_cnt,
    input  dec_sel_e          dec_sel,
    output logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] top_start,
    output logic [ADDR_W-1:0] top_end,
    output logic [CNT_W-1:0]  top_cnt,
    output logic [ADDR_W-1:0] nxt_start,
    output logic [ADDR_W-1:0] nxt_end,
    output logic [CNT_W-1:0]  nxt_cnt
);

    logic [ADDR_W-1:0] start_q [DEPTH];
    logic [ADDR_W-1:0] end_q   [DEPTH];
    logic [CNT_W-1:0]  cnt_q   [DEPTH];
    logic [LVL_W-1:0]  lvl_popped;

    // Level once this cycle's pops are applied; a push writes there.
    assign lvl_popped = lvl - LVL_W'(pop_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                start_q[i] <= '0;
                end_q[i]   <= '0;
                cnt_q[i]   <= '0;
            end
        end else begin
            lvl <= lvl_popped + LVL_W'(push);
            for (int i = 0; i < DEPTH; i++) begin
                if (push && (int'(lvl_popped) == i)) begin
                    start_q[i] <= push_start;
                    end_q[i]   <= push_end;
                    cnt_q[i]   <= push_cnt;
                end else if ((dec_sel == DEC_TOP) && (int'(lvl) == i + 1)) begin
                    cnt_q[i] <= cnt_q[i] - CNT_W'(1);
                end else if ((dec_sel == DEC_NEXT) && (int'(lvl) == i + 2)) begin
                    cnt_q[i] <= cnt_q[i] - CNT_W'(1);
                end
            end
        end
    end

    // Innermost and second-innermost entries.
    always_comb begin
        top_start = '0;
        top_end   = '0;
        top_cnt   = '0;
        nxt_start = '0;
        nxt_end   = '0;
        nxt_cnt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(lvl) == i + 1) begin
                top_start = start_q[i];
                top_end   = end_q[i];
                top_cnt   = cnt_q[i];
            end
            if (int'(lvl) == i + 2) begin
                nxt_start = start_q[i];
                nxt_end   = end_q[i];
                nxt_cnt   = cnt_q[i];
            end
        end
    end

endmodule

// File: rtl/hwloop_match.sv
`timescale 1ns/1ps
module hwloop_match
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int LVL_W  = 3
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              abort,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [ADDR_W-1:0] top_start,
    input  logic [ADDR_W-1:0] top_end,
    input  logic [CNT_W-1:0]  top_cnt,
    input  logic [ADDR_W-1:0] nxt_start,
    input  logic [ADDR_W-1:0] nxt_end,
    input  logic [CNT_W-1:0]  nxt_cnt,
    output logic              redir,
    output logic [ADDR_W-1:0] redir_addr,
    output logic [1:0]        pop_n,
    output dec_sel_e          dec_sel,
    output logic              empty_pop
);

    logic has_top;
    logic has_nxt;

    assign has_top = (int'(lvl) >= 1);
    assign has_nxt = (int'(lvl) >= 2);

    always_comb begin
        redir      = 1'b0;
        redir_addr = '0;
        pop_n      = 2'd0;
        dec_sel    = DEC_NONE;
        empty_pop  = 1'b0;
        if (abort) begin
            if (has_top) begin
                pop_n = 2'd1;
            end else begin
                empty_pop = 1'b1;
            end
        end else if (has_top && (pc == top_end)) begin
            if (top_cnt > CNT_W'(1)) begin
                redir      = 1'b1;
                redir_addr = top_start;
                dec_sel    = DEC_TOP;
            end else begin
                pop_n = 2'd1;
                if (has_nxt && (pc == nxt_end)) begin
                    if (nxt_cnt > CNT_W'(1)) begin
                        redir      = 1'b1;
                        redir_addr = nxt_start;
                        dec_sel    = DEC_NEXT;
                    end else begin
                        pop_n = 2'd2;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/hwloop_ctrl.sv
`timescale 1ns/1ps
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              setup_valid,
    input  logic [CNT_W-1:0]  setup_count,
    input  logic [ADDR_W-1:0] setup_end_addr,
    input  logic [ADDR_W-1:0] setup_pc,
    input  logic              abort,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              loop_active,
    output logic              overflow,
    output logic              underflow
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    occ_state_e        occ_q, occ_d;
    logic [LVL_W-1:0]  stk_lvl;
    logic [LVL_W-1:0]  lvl_next;
    logic [ADDR_W-1:0] top_start, top_end, nxt_start, nxt_end;
    logic [CNT_W-1:0]  top_cnt, nxt_cnt;
    logic              m_redir;
    logic [ADDR_W-1:0] m_addr;
    logic [1:0]        pop_n;
    dec_sel_e          dec_sel;
    logic              empty_pop;
    logic              full_blocks;
    logic              push_ok;
    logic [CNT_W-1:0]  push_cnt;
    logic [ADDR_W-1:0] push_start;
    logic              overflow_q, underflow_q;

    function automatic occ_state_e occ_of(input logic [LVL_W-1:0] l);
        if (l == '0)             return ST_EMPTY;
        else if (int'(l) == DEPTH) return ST_FULL;
        else                     return ST_NESTED;
    endfunction

    hwloop_match #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_match (
        .pc        (pc_in),
        .abort     (abort),
        .lvl       (stk_lvl),
        .top_start (top_start),
        .top_end   (top_end),
        .top_cnt   (top_cnt),
        .nxt_start (nxt_start),
        .nxt_end   (nxt_end),
        .nxt_cnt   (nxt_cnt),
        .redir     (m_redir),
        .redir_addr(m_addr),
        .pop_n     (pop_n),
        .dec_sel   (dec_sel),
        .empty_pop (empty_pop)
    );

    // Setup is dropped only if the stack stays full after this cycle's pops.
    assign full_blocks = (occ_q == ST_FULL) && (pop_n == 2'd0);
    assign push_ok     = setup_valid && !full_blocks;
    assign push_cnt    = (setup_count == '0) ? CNT_W'(1) : setup_count;
    assign push_start  = setup_pc + ADDR_W'(1);
    assign lvl_next    = stk_lvl - LVL_W'(pop_n) + LVL_W'(push_ok);

    hwloop_stack #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_n     (pop_n),
        .push      (push_ok),
        .push_start(push_start),
        .push_end  (setup_end_addr),
        .push_cnt  (push_cnt),
        .dec_sel   (dec_sel),
        .lvl       (stk_lvl),
        .top_start (top_start),
        .top_end   (top_end),
        .top_cnt   (top_cnt),
        .nxt_start (nxt_start),
        .nxt_end   (nxt_end),
        .nxt_cnt   (nxt_cnt)
    );

    // Next-state logic: push, fill, release, drain.
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            ST_EMPTY: begin
                if (push_ok) occ_d = occ_of(lvl_next);
            end
            ST_NESTED: begin
                occ_d = occ_of(lvl_next);
            end
            ST_FULL: begin
                occ_d = occ_of(lvl_next);
            end
            default: occ_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= ST_EMPTY;
        else        occ_q <= occ_d;
    end

    // Sticky error flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow_q  <= 1'b0;
            underflow_q <= 1'b0;
        end else begin
            overflow_q  <= overflow_q  | (setup_valid & full_blocks);
            underflow_q <= underflow_q | empty_pop;
        end
    end

    // Outputs.
    always_comb begin
        unique case (occ_q)
            ST_EMPTY:  loop_active = 1'b0;
            ST_NESTED: loop_active = 1'b1;
            ST_FULL:   loop_active = 1'b1;
            default:   loop_active = 1'b0;
        endcase
        redirect_valid = m_redir;
        redirect_addr  = m_redir ? m_addr : '0;
        overflow       = overflow_q;
        underflow      = underflow_q;
    end

endmodule

// File: rtl/hwloop_ctrl_sva.sv
`timescale 1ns/1ps
module hwloop_ctrl_sva #(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             setup_valid,
    input logic             abort,
    input logic             redirect_valid,
    input logic             loop_active,
    input logic             overflow,
    input logic             underflow,
    input logic [LVL_W-1:0] depth
);

    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= DEPTH);

    a_r5_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_active |-> !redirect_valid);

    a_r1_setup_activates: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> loop_active);

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(setup_valid));

    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    a_r8_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(abort));

    a_r8_abort_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !redirect_valid);

endmodule

bind hwloop_ctrl hwloop_ctrl_sva #(
    .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .setup_valid   (setup_valid),
    .abort         (abort),
    .redirect_valid(redirect_valid),
    .loop_active   (loop_active),
    .overflow      (overflow),
    .underflow     (underflow),
    .depth         (stk_lvl)
);

// File: tb/hwloop_ctrl_test.sv
`timescale 1ns/1ps
module hwloop_ctrl_test;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] pc_in;
    logic          setup_valid;
    logic [CW-1:0] setup_count;
    logic [AW-1:0] setup_end_addr;
    logic [AW-1:0] setup_pc;
    logic          abort;
    logic          redirect_valid;
    logic [AW-1:0] redirect_addr;
    logic          loop_active;
    logic          overflow;
    logic          underflow;

    always #2.5 clk = ~clk;

    hwloop_ctrl #(.ADDR_W(AW), .CNT_W(CW), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .setup_valid(setup_valid),
        .setup_count(setup_count), .setup_end_addr(setup_end_addr),
        .setup_pc(setup_pc), .abort(abort), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .loop_active(loop_active),
        .overflow(overflow), .underflow(underflow)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int p_n;
    int p_at  [2];
    int p_cnt [2];
    int p_end [2];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one fetch cycle, then let combinational outputs settle.
    task automatic drive(input int pc, input bit sv, input int cnt,
                         input int ea, input bit ab);
        @(negedge clk);
        pc_in          = AW'(pc);
        setup_valid    = sv;
        setup_count    = CW'(cnt);
        setup_end_addr = AW'(ea);
        setup_pc       = AW'(pc);
        abort          = ab;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pc_in = '0; setup_valid = 1'b0; setup_count = '0;
        setup_end_addr = '0; setup_pc = '0; abort = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Fetch loop that follows redirects as a program counter would.
    task automatic run_prog(input int exit_pc, output int fetches,
                            output int redirs, output int bad_tgt,
                            output int bad_idle);
        int pc = 10;
        int guard = 0;
        fetches = 0; redirs = 0; bad_tgt = 0; bad_idle = 0;
        while (pc != exit_pc && guard < 5000) begin
            bit sv = 1'b0;
            int cnt = 0;
            int ea = 0;
            for (int k = 0; k < p_n; k++) begin
                if (pc == p_at[k]) begin
                    sv = 1'b1; cnt = p_cnt[k]; ea = p_end[k];
                end
            end
            drive(pc, sv, cnt, ea, 1'b0);
            fetches++;
            if (redirect_valid) begin
                bit hit = 1'b0;
                redirs++;
                for (int k = 0; k < p_n; k++)
                    if (int'(redirect_addr) == p_at[k] + 1) hit = 1'b1;
                if (!hit) bad_tgt++;
                pc = int'(redirect_addr);
            end else begin
                if (redirect_addr != '0) bad_idle++;
                pc = pc + 1;
            end
            guard++;
        end
    endtask

    initial begin
        #900000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int f, r, bt, bi, it;

        // R10: reset state
        do_reset();
        #1;
        check(loop_active == 1'b0, "R10", "loop_active after reset", loop_active, 0);
        check(redirect_valid == 1'b0, "R10", "redirect_valid after reset", redirect_valid, 0);
        check(overflow == 1'b0, "R10", "overflow after reset", overflow, 0);
        check(underflow == 1'b0, "R10", "underflow after reset", underflow, 0);

        // R1 / R2: setup at 10, count 3, end 12; redirect in the end-address cycle
        drive(10, 1'b1, 3, 12, 1'b0);
        check(loop_active == 1'b0, "R1", "loop_active in setup cycle", loop_active, 0);
        drive(11, 1'b0, 0, 0, 1'b0);
        check(loop_active == 1'b1, "R1", "loop_active after setup", loop_active, 1);
        check(redirect_valid == 1'b0, "R5", "no redirect mid-body", redirect_valid, 0);
        drive(12, 1'b0, 0, 0, 1'b0);
        check(redirect_valid == 1'b1, "R2", "same-cycle redirect", redirect_valid, 1);
        check(int'(redirect_addr) == 11, "R2", "redirect target", int'(redirect_addr), 11);

        // R3 / R4 / R2 / R5: single-loop sweep over count and body length
        for (int n = 0; n <= 5; n++) begin
            for (int len = 1; len <= 4; len++) begin
                do_reset();
                p_n = 1; p_at[0] = 10; p_cnt[0] = n; p_end[0] = 10 + len;
                run_prog(11 + len, f, r, bt, bi);
                it = (n == 0) ? 1 : n;
                check(f == 1 + it * len, (n == 0) ? "R4" : "R3",
                      "fetch count single loop", f, 1 + it * len);
                check(r == it - 1, "R2", "redirect count single loop", r, it - 1);
                check(bt == 0, "R2", "wrong redirect targets", bt, 0);
                check(bi == 0, "R5", "nonzero address without redirect", bi, 0);
                drive(0, 1'b0, 0, 0, 1'b0);
                check(loop_active == 1'b0, "R3", "stack popped after exit", loop_active, 0);
            end
        end

        // R6: nested loops with distinct end addresses
        for (int a = 1; a <= 3; a++) begin
            for (int b = 1; b <= 3; b++) begin
                do_reset();
                p_n = 2;
                p_at[0] = 10; p_cnt[0] = a; p_end[0] = 20;
                p_at[1] = 12; p_cnt[1] = b; p_end[1] = 14;
                run_prog(21, f, r, bt, bi);
                check(f == 1 + a * (8 + 2 * b), "R6", "fetch count nested", f, 1 + a * (8 + 2 * b));
                check(r == (a - 1) + a * (b - 1), "R6", "redirect count nested", r, (a - 1) + a * (b - 1));
                check(bt == 0, "R6", "wrong nested targets", bt, 0);
            end
        end

        // R9: inner and outer loops share an end address
        for (int a = 1; a <= 3; a++) begin
            for (int b = 1; b <= 3; b++) begin
                do_reset();
                p_n = 2;
                p_at[0] = 10; p_cnt[0] = a; p_end[0] = 15;
                p_at[1] = 12; p_cnt[1] = b; p_end[1] = 15;
                run_prog(16, f, r, bt, bi);
                check(f == 1 + a * (2 + 3 * b), "R9", "fetch count shared end", f, 1 + a * (2 + 3 * b));
                check(r == (a - 1) + a * (b - 1), "R9", "redirect count shared end", r, (a - 1) + a * (b - 1));
                check(bt == 0, "R9", "wrong shared-end targets", bt, 0);
                drive(0, 1'b0, 0, 0, 1'b0);
                check(loop_active == 1'b0, "R9", "both loops retired", loop_active, 0);
            end
        end

        // R8: abort blocks the test, pops inner, restores outer; underflow
        do_reset();
        drive(10, 1'b1, 2, 30, 1'b0);
        drive(11, 1'b1, 3, 20, 1'b0);
        drive(12, 1'b0, 0, 0, 1'b0);
        drive(20, 1'b0, 0, 0, 1'b1);
        check(redirect_valid == 1'b0, "R8", "abort blocks redirect", redirect_valid, 0);
        drive(20, 1'b0, 0, 0, 1'b0);
        check(redirect_valid == 1'b0, "R8", "inner loop gone after abort", redirect_valid, 0);
        drive(30, 1'b0, 0, 0, 1'b0);
        check(redirect_valid == 1'b1 && int'(redirect_addr) == 11, "R8",
              "outer loop restored", int'(redirect_addr), 11);
        drive(31, 1'b0, 0, 0, 1'b1);
        drive(32, 1'b0, 0, 0, 1'b0);
        check(loop_active == 1'b0, "R8", "stack empty after aborts", loop_active, 0);
        check(underflow == 1'b0, "R8", "no underflow yet", underflow, 0);
        drive(33, 1'b0, 0, 0, 1'b1);
        drive(34, 1'b0, 0, 0, 1'b0);
        check(underflow == 1'b1, "R8", "underflow on empty abort", underflow, 1);
        drive(35, 1'b0, 0, 0, 1'b0);
        check(underflow == 1'b1, "R8", "underflow sticky", underflow, 1);

        // R7: overflow on a full stack, fifth setup ignored
        do_reset();
        for (int i = 0; i < DP; i++) drive(100 + i, 1'b1, 2, 200 + i, 1'b0);
        drive(150, 1'b0, 0, 0, 1'b0);
        check(overflow == 1'b0, "R7", "no overflow at exactly full", overflow, 0);
        drive(104, 1'b1, 2, 204, 1'b0);
        drive(204, 1'b0, 0, 0, 1'b0);
        check(overflow == 1'b1, "R7", "overflow raised", overflow, 1);
        check(redirect_valid == 1'b0, "R7", "dropped setup has no effect", redirect_valid, 0);
        drive(203, 1'b0, 0, 0, 1'b0);
        check(redirect_valid == 1'b1 && int'(redirect_addr) == 104, "R7",
              "top entry unchanged", int'(redirect_addr), 104);
        for (int i = 0; i < DP; i++) drive(160 + i, 1'b0, 0, 0, 1'b1);
        drive(170, 1'b0, 0, 0, 1'b0);
        check(loop_active == 1'b0, "R7", "depth was DEPTH", loop_active, 0);
        check(underflow == 1'b0, "R7", "no underflow while draining", underflow, 0);
        check(overflow == 1'b1, "R7", "overflow sticky", overflow, 1);

        // R10: reset clears the flags
        do_reset();
        #1;
        check(overflow == 1'b0, "R10", "overflow cleared", overflow, 0);
        check(underflow == 1'b0, "R10", "underflow cleared", underflow, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule